// File: doc/BRIEF.md
# Transport-Triggered Move Processor Core

This core executes a single kind of instruction: a move. Each 16-bit instruction names a source address in its upper byte and a destination address in its lower byte. In one cycle the selected source drives the shared 16-bit data bus, and the selected destination captures that value. All computation is a side effect of these moves. Writing the operand registers of a unit updates its result, which another move then reads from that unit's source address.

The core holds the following units:
- an adder;
- a separate AND unit and a separate OR unit;
- a three-stage pipelined multiplier;
- a conditional-branch destination backed by a branch-target register;
- a data-RAM port reached through an address register, a write-data destination and a read-data source.

Instructions come from an external program ROM, addressed by the program counter. There is no interlock, forwarding or stall of any kind. Software must space its moves so that each result is ready before it is read.

Top module: `movecore_top`

## Requirements
- R1: The instruction on `imem_data` holds the source address in bits 15:8 and the destination address in bits 7:0. The value moved in one cycle is held by the destination for the instruction that follows.
- R2: A source address with bit 7 set is an immediate. Its low 7 bits, zero-extended to 16 bits, go onto the bus.
- R3: Adder operands: destination 0x01 is A and destination 0x02 is B. Source 0x01 returns (A+B) mod 2^16.
- R4: AND and OR are independent units. AND takes A at destination 0x03 and B at 0x04, and its result is read at source 0x02. OR takes A at 0x05 and B at 0x06, and its result is read at source 0x03.
- R5: Multiplier operands: destination 0x07 is A and destination 0x08 is B. Source 0x04 returns the low 16 bits of A*B. The correct product is seen by a read issued four or more instructions after the move that writes the last operand. A read issued one instruction after that move returns the output register's previous contents, with no stall.
- R6: Destination 0x09 loads the branch-target register. A move to destination 0x0A with a nonzero value makes the next program counter equal to the branch target. A zero value lets execution fall through.
- R7: When no branch is taken, the program counter advances by one each cycle and wraps modulo 256.
- R8: Destination 0x0B loads the data-memory address register. A move to destination 0x0C writes the bus value to data memory at that address. Source 0x05 returns `dmem_rdata` for that address.
- R9: An unmapped source address (bit 7 clear, not 0x01 to 0x05) reads as zero. A move to an unmapped destination writes no memory and takes no branch.
- R10: Reset holds the program counter at 0 and clears every operand, pipeline, address and target register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 8 | Program counter, drives the program ROM address |
| imem_data | input | 16 | Instruction read from the program ROM |
| dmem_addr | output | 8 | Data-memory address register |
| dmem_wdata | output | 16 | Data-memory write value (the bus) |
| dmem_we | output | 1 | Data-memory write enable |
| dmem_rdata | input | 16 | Data-memory read value at `dmem_addr` |

## Verification
The hardest condition to reach from the ports is the multiplier hazard window. In that window a read lands while a product is still travelling through the pipeline, so the read must return the stale output rather than the new product. The stimulus is a program that writes both multiplier operands and then stores the multiplier result to data RAM at fixed instruction distances: one instruction later and four instructions later. The stored words expose both the stale and the settled values. Chained multiplies whose product exceeds 16 bits show the truncation.

// File: rtl/movecore_pkg.sv
package movecore_pkg;

  localparam int WORD_W     = 16;
  localparam int FIELD_W    = 8;
  localparam int MUL_STAGES = 3;
  localparam int NUM_LOGIC_UNITS = 3;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;

  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2} unit_op_e;

  // destination map; unit u has A at 2u+1, B at 2u+2
  localparam field_t DST_MUL_A  = 8'h07;
  localparam field_t DST_MUL_B  = 8'h08;
  localparam field_t DST_BTGT   = 8'h09;
  localparam field_t DST_BCOND  = 8'h0A;
  localparam field_t DST_MADDR  = 8'h0B;
  localparam field_t DST_MDATA  = 8'h0C;

  // source map; unit u result at u+1
  localparam field_t SRC_MUL    = 8'h04;
  localparam field_t SRC_MEMRD  = 8'h05;

  function automatic word_t unit_apply(unit_op_e op, word_t a, word_t b);
    case (op)
      OP_ADD:  return a + b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      default: return '0;
    endcase
  endfunction

  function automatic word_t mul_low(word_t a, word_t b);
    logic [2*WORD_W-1:0] full;
    full = a * b;
    return full[WORD_W-1:0];
  endfunction

  function automatic word_t imm_ext(logic [FIELD_W-2:0] v);
    return word_t'(v);
  endfunction

  function automatic logic dst_mapped(field_t d);
    return (d >= 8'h01) && (d <= DST_MDATA);
  endfunction

endpackage

// File: rtl/mc_fetch.sv
module mc_fetch #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= '0;
    else if (br_taken) pc <= br_target;
    else               pc <= pc + 1'b1;
  end
endmodule

// File: rtl/mc_opnd_unit.sv
module mc_opnd_unit
  import movecore_pkg::*;
#(
  parameter unit_op_e OP = OP_ADD
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_a,
  input  logic  we_b,
  input  word_t bus,
  output word_t result
);
  word_t a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (we_a) a_q <= bus;
      if (we_b) b_q <= bus;
    end
  end

  assign result = unit_apply(OP, a_q, b_q);
endmodule

// File: rtl/mc_mul_pipe.sv
module mc_mul_pipe
  import movecore_pkg::*;
#(
  parameter int STAGES = MUL_STAGES
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_a,
  input  logic  we_b,
  input  word_t bus,
  output word_t a_q,
  output word_t b_q,
  output word_t result
);
  localparam int LAST = STAGES - 1;

  word_t stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      if (we_a) a_q <= bus;
      if (we_b) b_q <= bus;
      stg[0] <= mul_low(a_q, b_q);
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign result = stg[LAST];
endmodule

// File: rtl/movecore_top.sv
module movecore_top
  import movecore_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int DM_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [WORD_W-1:0]  imem_data,
  output logic [DM_AW-1:0]   dmem_addr,
  output logic [WORD_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [WORD_W-1:0]  dmem_rdata
);
  // decoded fields and named internal events
  field_t          src, dst;
  word_t           bus;
  logic            br_taken;
  logic            btgt_we, maddr_we;
  logic [PC_W-1:0] btarget;
  logic [DM_AW-1:0] maddr;
  word_t           unit_res [NUM_LOGIC_UNITS];
  word_t           mul_res, mul_a, mul_b;

  assign src = imem_data[WORD_W-1:FIELD_W];
  assign dst = imem_data[FIELD_W-1:0];

  // source selection onto the bus
  always_comb begin
    bus = '0;
    if (src[FIELD_W-1]) begin
      bus = imm_ext(src[FIELD_W-2:0]);
    end else begin
      case (src)
        8'h01:     bus = unit_res[0];
        8'h02:     bus = unit_res[1];
        8'h03:     bus = unit_res[2];
        SRC_MUL:   bus = mul_res;
        SRC_MEMRD: bus = dmem_rdata;
        default:   bus = '0;
      endcase
    end
  end

  // operand units: adder, AND, OR
  for (genvar u = 0; u < NUM_LOGIC_UNITS; u++) begin : g_unit
    localparam field_t A_ADDR = field_t'(2*u + 1);
    localparam field_t B_ADDR = field_t'(2*u + 2);
    mc_opnd_unit #(.OP(unit_op_e'(u))) unit_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_a   (dst == A_ADDR),
      .we_b   (dst == B_ADDR),
      .bus    (bus),
      .result (unit_res[u])
    );
  end

  mc_mul_pipe #(.STAGES(MUL_STAGES)) mul_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_a   (dst == DST_MUL_A),
    .we_b   (dst == DST_MUL_B),
    .bus    (bus),
    .a_q    (mul_a),
    .b_q    (mul_b),
    .result (mul_res)
  );

  // branch target and memory address registers
  assign btgt_we  = (dst == DST_BTGT);
  assign maddr_we = (dst == DST_MADDR);
  assign br_taken = (dst == DST_BCOND) && (bus != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btarget <= '0;
      maddr   <= '0;
    end else begin
      if (btgt_we)  btarget <= bus[PC_W-1:0];
      if (maddr_we) maddr   <= bus[DM_AW-1:0];
    end
  end

  mc_fetch #(.PC_W(PC_W)) fetch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_taken  (br_taken),
    .br_target (btarget),
    .pc        (imem_addr)
  );

  assign dmem_addr  = maddr;
  assign dmem_wdata = bus;
  assign dmem_we    = (dst == DST_MDATA);
endmodule

// File: rtl/movecore_chk.sv
module movecore_chk
  import movecore_pkg::*;
#(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc,
  input field_t          dst,
  input logic            br_taken,
  input logic [PC_W-1:0] btarget,
  input logic            dmem_we,
  input word_t           mul_a,
  input word_t           mul_b,
  input word_t           mul_res
);
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> pc == $past(pc) + 1'b1);

  assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> pc == $past(btarget));

  assert_mul_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> mul_res == mul_low($past(mul_a, 3), $past(mul_b, 3)));

  assert_unmapped_noeffect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_mapped(dst) |-> (!dmem_we && !br_taken));
endmodule

bind movecore_top movecore_chk #(.PC_W(PC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pc       (imem_addr),
  .dst      (dst),
  .br_taken (br_taken),
  .btarget  (btarget),
  .dmem_we  (dmem_we),
  .mul_a    (mul_a),
  .mul_b    (mul_b),
  .mul_res  (mul_res)
);

// File: tb/movecore_top_tb_top.sv
`timescale 1ns/1ps
module movecore_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr;
  logic [15:0] imem_data;
  logic [7:0]  dmem_addr;
  logic [15:0] dmem_wdata;
  logic        dmem_we;
  logic [15:0] dmem_rdata;

  logic [15:0] rom [0:255];
  logic [15:0] ram [0:255];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign imem_data  = rom[imem_addr];
  assign dmem_rdata = ram[dmem_addr];
  always @(posedge clk) if (dmem_we) ram[dmem_addr] <= dmem_wdata;

  movecore_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  // address codes taken from the requirements
  localparam logic [7:0] A_ADD = 8'h01, B_ADD = 8'h02, A_AND = 8'h03, B_AND = 8'h04;
  localparam logic [7:0] A_OR = 8'h05, B_OR = 8'h06, A_MUL = 8'h07, B_MUL = 8'h08;
  localparam logic [7:0] TGT = 8'h09, COND = 8'h0A, MA = 8'h0B, MD = 8'h0C;
  localparam logic [7:0] R_ADD = 8'h01, R_AND = 8'h02, R_OR = 8'h03, R_MUL = 8'h04, R_MEM = 8'h05;

  function automatic logic [15:0] mv(input logic [7:0] s, input logic [7:0] d);
    return {s, d};
  endfunction
  function automatic logic [7:0] im(input logic [6:0] v);
    return {1'b1, v};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      rom[i] = 16'h0000;
      ram[i] = 16'hFFFF;
    end
  endtask

  task automatic start();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_alu();
    clear_mem();
    rom[0] = mv(im(100), A_ADD);  rom[1] = mv(im(77), B_ADD);
    rom[2] = mv(im(7'h6C), A_AND); rom[3] = mv(im(7'h3A), B_AND);
    rom[4] = mv(im(7'h6C), A_OR);  rom[5] = mv(im(7'h3A), B_OR);
    rom[6] = mv(im(1), MA);  rom[7] = mv(R_ADD, MD);
    rom[8] = mv(im(2), MA);  rom[9] = mv(R_AND, MD);
    rom[10] = mv(im(3), MA); rom[11] = mv(R_OR, MD);
    rom[12] = mv(R_ADD, A_ADD);
    rom[13] = mv(im(4), MA); rom[14] = mv(R_ADD, MD);
    start();
    step(20);
    check("R3 add result", ram[1], 16'd177);
    check("R4 and result", ram[2], 16'h0028);
    check("R4 or result", ram[3], 16'h007E);
    check("R1 result moved back as operand", ram[4], 16'd254);
  endtask

  task automatic t_reset();
    clear_mem();
    rom[0] = mv(im(9), MD);
    rom[1] = mv(im(70), MA); rom[2] = mv(R_ADD, MD);
    rom[3] = mv(im(71), MA); rom[4] = mv(R_AND, MD);
    rom[5] = mv(im(72), MA); rom[6] = mv(R_OR, MD);
    rom[7] = mv(im(73), MA); rom[8] = mv(R_MUL, MD);
    rst_n = 1'b0;
    step(2);
    check("R10 pc held at zero in reset", imem_addr, 8'h00);
    start();
    step(12);
    check("R10 address register cleared", ram[0], 16'd9);
    check("R10 adder cleared", ram[70], 16'h0000);
    check("R10 and unit cleared", ram[71], 16'h0000);
    check("R10 or unit cleared", ram[72], 16'h0000);
    check("R10 multiplier cleared", ram[73], 16'h0000);
  endtask

  task automatic t_imm();
    clear_mem();
    rom[0] = mv(im(20), MA); rom[1] = mv(im(127), MD);
    rom[2] = mv(im(21), MA); rom[3] = mv(im(0), MD);
    start();
    step(6);
    check("R2 immediate 127", ram[20], 16'h007F);
    check("R2 immediate zero", ram[21], 16'h0000);
  endtask

  task automatic t_mul();
    clear_mem();
    rom[0] = mv(im(30), MA);
    rom[1] = mv(im(3), A_MUL); rom[2] = mv(im(5), B_MUL);
    rom[3] = mv(R_MUL, MD);                 // one after last operand
    rom[4] = mv(im(31), MA);
    rom[6] = mv(R_MUL, MD);                 // four after last operand
    rom[10] = mv(im(127), A_MUL); rom[11] = mv(im(127), B_MUL);
    rom[15] = mv(R_MUL, A_MUL);   rom[16] = mv(im(5), B_MUL);
    rom[20] = mv(im(33), MA);     rom[21] = mv(R_MUL, MD);
    start();
    step(25);
    check("R5 hazard read returns stale output", ram[30], 16'h0000);
    check("R5 product after latency", ram[31], 16'd15);
    check("R5 product truncated to 16 bits", ram[33], 16'd15109);
  endtask

  task automatic t_mem();
    clear_mem();
    ram[40] = 16'h1234;
    rom[0] = mv(im(40), MA); rom[1] = mv(R_MEM, A_ADD);
    rom[2] = mv(im(1), B_ADD);
    rom[3] = mv(im(41), MA); rom[4] = mv(R_ADD, MD);
    start();
    step(1);
    check("R8 address register drives dmem_addr", dmem_addr, 8'd40);
    step(6);
    check("R8 read then write", ram[41], 16'h1235);
  endtask

  task automatic t_branch();
    clear_mem();
    rom[0] = mv(im(10), TGT); rom[1] = mv(im(0), COND);
    rom[2] = mv(im(50), MA);  rom[3] = mv(im(1), MD);
    rom[4] = mv(im(5), COND);
    rom[5] = mv(im(51), MA);  rom[6] = mv(im(2), MD);
    rom[10] = mv(im(52), MA); rom[11] = mv(im(3), MD);
    rom[12] = mv(im(13), TGT); rom[13] = mv(im(1), COND);
    start();
    step(2);
    check("R6 zero condition falls through", imem_addr, 8'd2);
    step(2);
    check("R7 pc steps by one", imem_addr, 8'd4);
    step(1);
    check("R6 nonzero condition branches", imem_addr, 8'd10);
    step(10);
    check("R6 self loop holds pc", imem_addr, 8'd13);
    check("R6 fall-through path wrote", ram[50], 16'd1);
    check("R6 skipped moves not executed", ram[51], 16'hFFFF);
    check("R6 target path wrote", ram[52], 16'd3);
  endtask

  task automatic t_wrap();
    clear_mem();
    start();
    step(255);
    check("R7 pc reaches 255", imem_addr, 8'd255);
    step(1);
    check("R7 pc wraps to zero", imem_addr, 8'd0);
  endtask

  task automatic t_unmapped();
    clear_mem();
    rom[0] = mv(im(60), MA);
    rom[1] = mv(im(9), 8'h3F);
    rom[2] = mv(8'h40, MD);
    start();
    step(1);
    check("R9 unmapped destination no write", dmem_we, 1'b0);
    step(1);
    check("R9 unmapped destination no branch", imem_addr, 8'd2);
    step(2);
    check("R9 unmapped source reads zero", ram[60], 16'h0000);
    check("R9 address register untouched", ram[9], 16'hFFFF);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    t_alu();
    t_reset();
    t_imm();
    t_mul();
    t_mem();
    t_branch();
    t_wrap();
    t_unmapped();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule